// File: doc/BRIEF.md
# I2C Target Interface with 7-bit and 10-bit Addressing

This block is the bus-facing half of an I2C target. It watches the synchronized SCL and SDA lines, finds START, repeated START and STOP conditions, and assembles bytes from the bits sampled on each SCL rising edge. It drives SDA only through an open-drain enable: `sda_oe` high pulls the line low, and low lets the pull-up win.

Address recognition works in one of two modes. In the first, the block answers a 7-bit address. In the second, it answers a 10-bit address sent as a header byte followed by a low-address byte. Once an address matches, written bytes go to the local side on a one-cycle strobe. For a read, the block asks the local side for each byte with a one-cycle request pulse and then shifts that byte out. The local side also gets single-cycle markers where a transaction opens and closes.

The local side must present `rd_data` on the clock after `rd_req` and hold it until the next `rd_req`. The block never stretches SCL.

Top module: `i2c_tgt`

## Requirements
- R1: An SDA fall while SCL stays high is a START. An SDA rise while SCL stays high is a STOP. After a STOP, `sda_oe` is 0 and the block stays silent until the next START. After reset, `sda_oe`, `wr_stb`, `rd_req`, `txn_start` and `txn_stop` are 0.
- R2: With `mode10`=0, the first byte after a START is captured MSB first, one bit on each SCL rise. If its upper seven bits equal `own_addr7`, the block holds SDA low through the ninth clock (ACK). Bit 0 of that byte selects read (1) or write (0).
- R3: If the address does not match, SDA stays released for the ninth clock (NACK) and for every later clock until the next START. No `wr_stb`, `rd_req` or `txn_start` is produced. A 7-bit address is never matched while `mode10`=1.
- R4: With `mode10`=1, a header byte of the form 11110 b9 b8 0 is ACKed when b9 b8 equal `own_addr10[9:8]`. The following byte is ACKed when it equals `own_addr10[7:0]`, and that second ACK starts the write.
- R5: In 10-bit mode, a second byte that differs from `own_addr10[7:0]` is NACKed, and the data bytes after it are ignored.
- R6: In a matched write, every data byte is ACKed. Each such byte produces one single-cycle `wr_stb` pulse, with `wr_data` carrying that byte.
- R7: In a matched read, one single-cycle `rd_req` pulse precedes every byte sent. The byte is shifted out MSB first. `sda_oe` is only asserted in a cycle that follows one with SCL low, so the data bit is steady while SCL is high.
- R8: During a read, a controller ACK (SDA low on the ninth clock) makes the block fetch and send another byte. A NACK makes it release SDA and send nothing more.
- R9: A repeated START restarts address decoding. After a full 10-bit write selection, a repeated START followed by the header 11110 b9 b8 1 is ACKed and starts a read without a second address byte. A STOP clears this selection, so the same header right after a START is NACKed.
- R10: A START or STOP in the middle of a byte discards that byte without a `wr_stb`. The next transaction is decoded normally.
- R11: `txn_start` pulses once when the block accepts its final address byte. `txn_stop` pulses once when a STOP or START ends a transaction in which the block was addressed. The two never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| mode10 | input | 1 | 1 selects 10-bit addressing |
| own_addr7 | input | 7 | 7-bit address of this target |
| own_addr10 | input | 10 | 10-bit address of this target |
| wr_stb | output | 1 | Pulse: accepted write byte on wr_data |
| wr_data | output | 8 | Last accepted write byte |
| rd_req | output | 1 | Pulse: supply the next read byte |
| rd_data | input | 8 | Read byte, valid the clock after rd_req |
| txn_start | output | 1 | Pulse: target addressed |
| txn_stop | output | 1 | Pulse: addressed transaction ended |

## Verification
A wrong decoding state shows up on SDA in the ninth clock of the affected byte: either an ACK where a NACK was due or the reverse. A wrong state after an address also appears there as a missing or spurious `wr_stb` at that same ACK. A fault in the transmit path appears as a wrong bit, or as SDA changing while SCL is high, during the next SCL high phase. A lost 10-bit selection only becomes visible at the next repeated-START read header, which is therefore exercised both with and without a STOP before it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int A7_W   = 7;
  localparam int A10_W  = 10;
  localparam int RXC_W  = $clog2(BYTE_W + 1);
  localparam int TXC_W  = $clog2(BYTE_W);
  localparam logic [4:0] TEN_PFX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } st_e;

  typedef enum logic [1:0] {
    RX_ADDR1,
    RX_ADDR2,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA moves while SCL is held high on both samples
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_rx_shift.sv
module i2c_tgt_rx_shift #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         full
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data <= '0;
      cnt  <= '0;
    end else if (shift_en) begin
      data <= {data[W-2:0], bit_in};
      cnt  <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CW'(W));
endmodule

// File: rtl/i2c_tgt_addr_dec.sv
module i2c_tgt_addr_dec
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              mode10,
  input  logic [A7_W-1:0]   own_addr7,
  input  logic [A10_W-1:0]  own_addr10,
  input  logic              ten_sel,
  output logic              ack_first,
  output logic              first_final,
  output logic              ack_second
);
  logic is_hdr, hdr_hit;

  assign is_hdr  = (byte_in[BYTE_W-1 -: 5] == TEN_PFX);
  assign hdr_hit = mode10 && (byte_in[2:1] == own_addr10[A10_W-1 -: 2]);

  always_comb begin
    if (is_hdr) begin
      // a read header is only valid once the full address was seen
      ack_first   = hdr_hit && (!byte_in[0] || ten_sel);
      first_final = byte_in[0];
    end else begin
      ack_first   = !mode10 && (byte_in[BYTE_W-1:1] == own_addr7);
      first_final = 1'b1;
    end
  end

  assign ack_second = (byte_in == own_addr10[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              mode10,
  input  logic [A7_W-1:0]   own_addr7,
  input  logic [A10_W-1:0]  own_addr10,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              txn_start,
  output logic              txn_stop
);
  st_e                state;
  rx_kind_e           rx_kind;
  logic               rd_mode, ten_sel, active, ack_pend;
  logic [BYTE_W-1:0]  tx_sr;
  logic [TXC_W-1:0]   tx_cnt;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic rx_clr, rx_shift_en, rx_full;
  logic [BYTE_W-1:0] rx_byte;
  logic ack_first, first_final, ack_second;

  i2c_tgt_line_mon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rx_shift_en = (state == ST_RX) && scl_rise;
  assign rx_clr      = start_det || stop_det || ((state == ST_RX_ACK) && scl_fall);

  i2c_tgt_rx_shift #(.W(BYTE_W), .CW(RXC_W)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .shift_en(rx_shift_en),
    .bit_in(sda_i), .data(rx_byte), .full(rx_full)
  );

  i2c_tgt_addr_dec u_dec (
    .byte_in(rx_byte), .mode10(mode10), .own_addr7(own_addr7),
    .own_addr10(own_addr10), .ten_sel(ten_sel),
    .ack_first(ack_first), .first_final(first_final), .ack_second(ack_second)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rx_kind   <= RX_ADDR1;
      rd_mode   <= 1'b0;
      ten_sel   <= 1'b0;
      active    <= 1'b0;
      ack_pend  <= 1'b0;
      tx_sr     <= '0;
      tx_cnt    <= '0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
      txn_start <= 1'b0;
      txn_stop  <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      rd_req    <= 1'b0;
      txn_start <= 1'b0;
      txn_stop  <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        ten_sel  <= 1'b0;
        active   <= 1'b0;
        txn_stop <= active;
      end else if (start_det) begin
        state    <= ST_RX;
        rx_kind  <= RX_ADDR1;
        sda_oe   <= 1'b0;
        active   <= 1'b0;
        txn_stop <= active;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_fall && rx_full) begin
              case (rx_kind)
                RX_ADDR1: begin
                  if (ack_first) begin
                    sda_oe  <= 1'b1;
                    state   <= ST_RX_ACK;
                    rd_mode <= rx_byte[0];
                    if (first_final) begin
                      txn_start <= 1'b1;
                      active    <= 1'b1;
                      rd_req    <= rx_byte[0];
                      rx_kind   <= RX_DATA;
                    end else begin
                      rx_kind <= RX_ADDR2;
                    end
                  end else begin
                    state   <= ST_IDLE;
                    ten_sel <= 1'b0;
                  end
                end
                RX_ADDR2: begin
                  if (ack_second) begin
                    sda_oe    <= 1'b1;
                    state     <= ST_RX_ACK;
                    ten_sel   <= 1'b1;
                    active    <= 1'b1;
                    txn_start <= 1'b1;
                    rx_kind   <= RX_DATA;
                  end else begin
                    state   <= ST_IDLE;
                    ten_sel <= 1'b0;
                  end
                end
                default: begin
                  sda_oe  <= 1'b1;
                  state   <= ST_RX_ACK;
                  wr_stb  <= 1'b1;
                  wr_data <= rx_byte;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                tx_sr  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                tx_cnt <= '0;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (tx_cnt == TXC_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sr[BYTE_W-2];
                tx_cnt <= tx_cnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_pend <= ~sda_i;
              rd_req   <= ~sda_i;
            end else if (scl_fall) begin
              if (ack_pend) begin
                tx_sr  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                tx_cnt <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic wr_stb,
  input logic rd_req,
  input logic txn_start,
  input logic txn_stop
);
  // R7
  oe_assert_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_i));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe);

  // R6
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R7
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R11
  txn_marker_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(txn_start && txn_stop));
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .rd_req(rd_req), .txn_start(txn_start), .txn_stop(txn_stop)
);

// File: tb/i2c_tgt_tb.sv
module i2c_tgt_tb;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic mode10 = 1'b0;
  logic [6:0] own7 = 7'h2A;
  logic [9:0] own10 = 10'h2D7;
  logic sda_oe, wr_stb, rd_req, txn_start, txn_stop;
  logic [7:0] wr_data, rd_data;
  logic sda_line;

  int checks = 0, errors = 0;
  int wr_cnt = 0, ts_cnt = 0, tp_cnt = 0, rq_cnt = 0, rd_idx = 0;
  logic [7:0] wr_log [0:15];
  logic [7:0] rd_mem [0:3];
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_tgt u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .mode10(mode10), .own_addr7(own7), .own_addr10(own10),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .txn_start(txn_start), .txn_stop(txn_stop)
  );

  initial begin
    rd_mem[0] = 8'hC3; rd_mem[1] = 8'h5A; rd_mem[2] = 8'hE1; rd_mem[3] = 8'h0F;
  end

  always @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else begin
      if (rd_req) begin
        rd_data <= rd_mem[rd_idx[1:0]];
        rd_idx  <= rd_idx + 1;
        rq_cnt  <= rq_cnt + 1;
      end
      if (wr_stb) begin
        wr_log[wr_cnt[3:0]] <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (txn_start) ts_cnt <= ts_cnt + 1;
      if (txn_stop)  tp_cnt <= tp_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_q();
    scl_drv = 1'b1; wait_q();
    sda_drv = 1'b0; wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_q();
    scl_drv = 1'b1; wait_q();
    sda_drv = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wait_q();
      scl_drv = 1'b1; wait_q(); wait_q();
      scl_drv = 1'b0; wait_q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_drv = 1'b1; wait_q();
    scl_drv = 1'b1; wait_q();
    acked = ~sda_line; wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d, output bit steady);
    steady = 1'b1;
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_drv = 1'b1; wait_q();
      d[i] = sda_line; wait_q();
      if (sda_line !== d[i]) steady = 1'b0;
      scl_drv = 1'b0;
    end
    sda_drv = ~ack; wait_q();
    scl_drv = 1'b1; wait_q(); wait_q();
    scl_drv = 1'b0; wait_q();
    sda_drv = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0 && wr_stb == 1'b0 && rd_req == 1'b0, "R1 reset outputs", sda_oe, 0);
    chk(txn_start == 1'b0 && txn_stop == 1'b0, "R1 reset markers", txn_start, 0);
  endtask

  task automatic t_write7();
    bit a; int w0 = wr_cnt, s0 = ts_cnt, p0 = tp_cnt;
    mode10 = 1'b0;
    bus_start();
    send_byte(8'h54, a); chk(a, "R2 7-bit write address ACK", a, 1);
    send_byte(8'hA5, a); chk(a, "R6 data byte ACK", a, 1);
    send_byte(8'h3C, a); chk(a, "R6 data byte ACK", a, 1);
    bus_stop();
    chk(wr_cnt == w0 + 2, "R6 write strobe count", wr_cnt - w0, 2);
    chk(wr_log[w0[3:0]] == 8'hA5, "R6 first written byte", wr_log[w0[3:0]], 8'hA5);
    chk(wr_log[w0[3:0] + 4'd1] == 8'h3C, "R6 second written byte", wr_log[w0[3:0] + 4'd1], 8'h3C);
    chk(ts_cnt == s0 + 1 && tp_cnt == p0 + 1, "R11 start/stop markers", ts_cnt - s0, 1);
    chk(sda_oe == 1'b0, "R1 released after STOP", sda_oe, 0);
  endtask

  task automatic t_nomatch7();
    bit a; int w0 = wr_cnt, s0 = ts_cnt;
    bus_start();
    send_byte(8'h56, a); chk(!a, "R3 wrong 7-bit address NACK", a, 0);
    send_byte(8'h00, a); chk(!a, "R3 later byte stays NACK", a, 0);
    bus_stop();
    chk(wr_cnt == w0 && ts_cnt == s0, "R3 no strobes on mismatch", wr_cnt - w0, 0);
  endtask

  task automatic t_read7();
    bit a, st; logic [7:0] d; int q0 = rq_cnt;
    bus_start();
    send_byte(8'h55, a); chk(a, "R2 7-bit read address ACK", a, 1);
    recv_byte(1'b1, d, st);
    chk(d == 8'hC3, "R7 first read byte", d, 8'hC3);
    chk(st, "R7 SDA steady while SCL high", st, 1);
    recv_byte(1'b0, d, st);
    chk(d == 8'h5A, "R8 byte after controller ACK", d, 8'h5A);
    chk(sda_oe == 1'b0, "R8 released after controller NACK", sda_oe, 0);
    bus_stop();
    chk(rq_cnt == q0 + 2, "R7 one request per byte", rq_cnt - q0, 2);
  endtask

  task automatic t_ten_write_restart_read();
    bit a, st; logic [7:0] d; int w0 = wr_cnt, s0 = ts_cnt, p0 = tp_cnt;
    mode10 = 1'b1;
    bus_start();
    send_byte(8'hF4, a); chk(a, "R4 10-bit header ACK", a, 1);
    chk(ts_cnt == s0, "R11 no marker after header alone", ts_cnt - s0, 0);
    send_byte(8'hD7, a); chk(a, "R4 10-bit low byte ACK", a, 1);
    send_byte(8'h11, a); chk(a, "R6 10-bit data ACK", a, 1);
    chk(wr_cnt == w0 + 1 && wr_log[w0[3:0]] == 8'h11, "R4 10-bit write data", wr_log[w0[3:0]], 8'h11);
    bus_start();
    chk(tp_cnt == p0 + 1, "R11 repeated START closes transaction", tp_cnt - p0, 1);
    send_byte(8'hF5, a); chk(a, "R9 read header after repeated START ACK", a, 1);
    recv_byte(1'b0, d, st);
    chk(d == 8'hE1, "R9 10-bit read byte", d, 8'hE1);
    bus_stop();
    chk(ts_cnt == s0 + 2 && tp_cnt == p0 + 2, "R11 marker counts", ts_cnt - s0, 2);
  endtask

  task automatic t_ten_errors();
    bit a; int w0 = wr_cnt;
    bus_start();
    send_byte(8'hF5, a); chk(!a, "R9 read header after STOP NACK", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hF4, a); chk(a, "R4 header ACK", a, 1);
    send_byte(8'hD6, a); chk(!a, "R5 wrong low byte NACK", a, 0);
    send_byte(8'h99, a); chk(!a, "R5 data ignored", a, 0);
    bus_stop();
    chk(wr_cnt == w0, "R5 no write strobe", wr_cnt - w0, 0);
    bus_start();
    send_byte(8'hF0, a); chk(!a, "R4 header with other top bits NACK", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h54, a); chk(!a, "R3 7-bit address ignored in 10-bit mode", a, 0);
    bus_stop();
  endtask

  task automatic t_abort();
    bit a; int w0 = wr_cnt;
    mode10 = 1'b0;
    bus_start();
    send_byte(8'h54, a); chk(a, "R10 address ACK", a, 1);
    send_bits(8'hF0, 4);
    bus_stop();
    chk(wr_cnt == w0 && sda_oe == 1'b0, "R10 partial byte dropped", wr_cnt - w0, 0);
    bus_start();
    send_byte(8'h54, a);
    send_bits(8'h0F, 5);
    bus_start();
    send_byte(8'h54, a); chk(a, "R10 decode after START abort", a, 1);
    send_byte(8'h77, a); chk(a, "R10 data ACK", a, 1);
    bus_stop();
    chk(wr_cnt == w0 + 1 && wr_log[w0[3:0]] == 8'h77, "R10 only full byte written", wr_cnt - w0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write7();
    t_nomatch7();
    t_read7();
    t_ten_write_restart_read();
    t_ten_errors();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule